// File: doc/BRIEF.md
# Phase-Selecting Clock-Domain Retimer

This block moves data words from a data-clock domain into a main-clock domain. It models both clocks inside one system clock that runs four times faster than the data rate. Each data-clock period is therefore split into four ticks, numbered 0 to 3. Tick 0 is the data-clock rising edge, signalled by `dataClkTick`. The main-clock rising edge arrives as a one-cycle pulse on `mainClkTick`, once per period, at some tick position.

A captured word is held in a first register at tick 0. An intermediate retiming register then picks it up at one of three candidate ticks: a quarter, a half or three quarters of a period after the data edge. An output register launches the retimed word on the main-clock tick.

The retiming tick comes from one of two sources. In automatic mode, the block notes the tick position of each main-clock edge and selects a phase that keeps clear of it. In manual mode, a phase driven on a port is used instead. The block reports the phase in use and a lock flag.

Top module: `phase_retimer`

## Requirements
- R1: After reset `dataOut` is 0, `locked` is 0 and, in automatic mode, `phaseCode` is 2.
- R2: Phase codes are 1 = tick 1 (90 degrees), 2 = tick 2 (180 degrees) and 3 = tick 3 (270 degrees). The word presented with `dataClkTick` in period k is copied into the retiming register at tick p of that period, where p is the phase in use. A main tick at position m then puts word k on `dataOut` if m > p, and word k-1 if m <= p.
- R3: In automatic mode, each main tick at position m measures a phase. A phase p is unsafe when m equals p or m equals (p+1) mod 4. The lowest-coded safe phase is taken: m=0 gives 1, m=1 gives 2, m=2 gives 3 and m=3 gives 1. `phaseCode` shows this phase from the cycle after that main tick.
- R4: In automatic mode, `locked` rises on the cycle after the 4th consecutive main tick that measures the same phase, and not earlier.
- R5: When a main tick measures a phase that differs from the previous one, `locked` is 0 on the next cycle, and the count of consecutive matches restarts at one.
- R6: With `manualEn` high, `phaseCode` equals `manualPhase` (for codes 1 to 3), the retiming tick follows it, and `locked` is 1 in the same cycle.
- R7: With `manualEn` high and `manualPhase` = 0 (the reserved code), the block uses phase 2.
- R8: `dataOut` changes only on the cycle after a main tick. On every other cycle it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 4x the data rate |
| rstN | input | 1 | Active-low synchronous reset |
| dataClkTick | input | 1 | Data-clock rising edge (tick 0) |
| mainClkTick | input | 1 | Main-clock rising edge |
| dataIn | input | DATA_W | Captured data word, valid with `dataClkTick` |
| manualEn | input | 1 | Forces the phase from `manualPhase` |
| manualPhase | input | 2 | Forced phase code |
| dataOut | output | DATA_W | Retimed word in the main domain |
| phaseCode | output | 2 | Phase in use |
| locked | output | 1 | Phase lock indication |

## Verification
The hardest case to reach is the loss of lock while the block is running. It needs a stable run of main ticks at one position, and then a move to a position that measures a different phase, all without a reset in between. The bench runs automatic mode locked at position 0. It then shifts the main tick to position 1 mid-stream and tracks the lock count as it restarts. A sweep of every main position against every manual code, including the reserved one, covers the case where the launch tick lands on the retiming tick itself.

// File: rtl/retimer_pkg.sv
package retimer_pkg;
  localparam int TICKS_PER_PERIOD = 4;
  localparam int POS_W = $clog2(TICKS_PER_PERIOD);

  typedef logic [1:0] phase_t;
  localparam phase_t PHASE_DEFAULT = 2'd2;

  typedef struct packed {
    logic captureEn;
    logic retimeEn;
    logic launchEn;
  } strobe_t;
endpackage

// File: rtl/retimer_ctrl.sv
module retimer_ctrl
  import retimer_pkg::*;
#(
  parameter int LOCK_COUNT = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    dataClkTick,
  input  logic    mainClkTick,
  input  logic    manualEn,
  input  phase_t  manualPhase,
  output phase_t  phaseCode,
  output logic    locked,
  output strobe_t strobes
);
  localparam int CNT_W = $clog2(LOCK_COUNT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_COUNT);

  logic [POS_W-1:0] posQ, curPos;
  phase_t detPhase, autoPhaseQ, selPhase;
  logic [CNT_W-1:0] matchCnt;
  logic autoLocked;

  // tick position within the current data-clock period
  always_comb curPos = dataClkTick ? '0 : POS_W'(posQ + 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) posQ <= '0;
    else       posQ <= curPos;
  end

  // lowest-coded phase p with curPos != p and curPos != p+1
  always_comb begin
    unique case (curPos)
      2'd0:    detPhase = 2'd1;
      2'd1:    detPhase = 2'd2;
      2'd2:    detPhase = 2'd3;
      default: detPhase = 2'd1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      autoPhaseQ <= PHASE_DEFAULT;
      matchCnt   <= '0;
    end else if (mainClkTick) begin
      autoPhaseQ <= detPhase;
      if (matchCnt != '0 && detPhase == autoPhaseQ)
        matchCnt <= (matchCnt == CNT_MAX) ? CNT_MAX : matchCnt + 1'b1;
      else
        matchCnt <= CNT_W'(1);
    end
  end

  always_comb autoLocked = (matchCnt == CNT_MAX);

  always_comb begin
    if (manualEn) selPhase = (manualPhase == 2'd0) ? PHASE_DEFAULT : manualPhase;
    else          selPhase = autoPhaseQ;
  end

  assign phaseCode = selPhase;
  assign locked    = manualEn | autoLocked;

  always_comb begin
    strobes.captureEn = dataClkTick;
    strobes.retimeEn  = (curPos == selPhase);
    strobes.launchEn  = mainClkTick;
  end

  AST_PHASE_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    phaseCode != 2'd0); // R2
  AST_MANUAL_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    manualEn |-> locked); // R6
  AST_AUTO_SAFE: assert property (@(posedge clk) disable iff (!rstN)
    (!manualEn && mainClkTick) |=> (manualEn ||
      (autoPhaseQ != $past(curPos) && 2'(autoPhaseQ + 2'd1) != $past(curPos)))); // R3
  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (!manualEn && mainClkTick && detPhase != autoPhaseQ) |=> (manualEn || !locked)); // R5
endmodule

// File: rtl/retimer_datapath.sv
module retimer_datapath
  import retimer_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  logic [DATA_W-1:0] captureQ, retimeQ, outQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      captureQ <= '0;
      retimeQ  <= '0;
      outQ     <= '0;
    end else begin
      if (strobes.captureEn) captureQ <= dataIn;
      if (strobes.retimeEn)  retimeQ  <= captureQ;
      if (strobes.launchEn)  outQ     <= retimeQ;
    end
  end

  assign dataOut = outQ;

  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.launchEn |=> $stable(dataOut)); // R8
  AST_RETIME_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.retimeEn |=> retimeQ == $past(captureQ)); // R2
endmodule

// File: rtl/phase_retimer.sv
module phase_retimer
  import retimer_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int LOCK_COUNT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataClkTick,
  input  logic              mainClkTick,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              manualEn,
  input  logic [1:0]        manualPhase,
  output logic [DATA_W-1:0] dataOut,
  output logic [1:0]        phaseCode,
  output logic              locked
);
  strobe_t strobes;

  retimer_ctrl #(.LOCK_COUNT(LOCK_COUNT)) u_ctrl (
    .clk(clk), .rstN(rstN), .dataClkTick(dataClkTick), .mainClkTick(mainClkTick),
    .manualEn(manualEn), .manualPhase(manualPhase), .phaseCode(phaseCode),
    .locked(locked), .strobes(strobes)
  );

  retimer_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: tb/phase_retimer_tb.sv
module phase_retimer_tb;
  localparam int DW = 12;
  logic clk = 0, rstN = 0, dataClkTick = 0, mainClkTick = 0, manualEn = 0;
  logic [DW-1:0] dataIn = '0;
  logic [1:0] manualPhase = '0;
  logic [DW-1:0] dataOut;
  logic [1:0] phaseCode;
  logic locked;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  phase_retimer #(.DATA_W(DW), .LOCK_COUNT(4)) u_dut (
    .clk(clk), .rstN(rstN), .dataClkTick(dataClkTick), .mainClkTick(mainClkTick),
    .dataIn(dataIn), .manualEn(manualEn), .manualPhase(manualPhase),
    .dataOut(dataOut), .phaseCode(phaseCode), .locked(locked));

  function automatic logic [DW-1:0] word(int k);
    return DW'(k * 37 + 5);
  endfunction

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; dataClkTick = 0; mainClkTick = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  // runs nPer periods with main tick at position m; ticks counts matching ticks
  task automatic runCase(int m, bit man, int mph, int nPer, bit fresh, int prevRun);
    int ticks = prevRun;
    logic [DW-1:0] lastOut;
    int expP, autoP;
    autoP = (m == 0) ? 1 : (m == 1) ? 2 : (m == 2) ? 3 : 1;
    expP  = man ? ((mph == 0) ? 2 : mph) : autoP;
    manualEn = man; manualPhase = 2'(mph);
    if (fresh) begin
      doReset();
      if (man) begin
        chk(mph == 0 ? "R7 reserved" : "R6 manual phase", int'(phaseCode), expP);
        chk("R6 immediate lock", int'(locked), 1);
      end
    end
    lastOut = dataOut;
    for (int c = 0; c < nPer * 4; c++) begin
      dataClkTick = (c % 4 == 0);
      mainClkTick = (c % 4 == m);
      dataIn = word(c / 4);
      @(negedge clk);
      if (c % 4 == m) begin
        ticks++;
        chk(man ? "R6 phase" : "R3 auto phase", int'(phaseCode), expP);
        chk(man ? "R6 lock" : (ticks == 1 && !fresh ? "R5 lock clear" : "R4 lock"),
            int'(locked), (man || ticks >= 4) ? 1 : 0);
        if (c / 4 >= 2)
          chk("R2 data", int'(dataOut), int'((m > expP) ? word(c / 4) : word(c / 4 - 1)));
      end else begin
        chk("R8 hold", int'(dataOut), int'(lastOut));
      end
      lastOut = dataOut;
    end
  endtask

  initial begin
    doReset();
    chk("R1 dataOut", int'(dataOut), 0);
    chk("R1 locked", int'(locked), 0);
    chk("R1 phase", int'(phaseCode), 2);
    for (int m = 0; m < 4; m++) runCase(m, 0, 0, 8, 1, 0);
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 4; p++) runCase(m, 1, p, 5, 1, 0);
    // lock loss: locked at position 0, then shift main tick to position 1
    runCase(0, 0, 0, 6, 1, 0);
    runCase(1, 0, 0, 6, 0, 0);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule